// File: doc/BRIEF.md
# Transfer-Completion Interrupt Reporter

This block tells a host processor that a bus transfer or a mode command has finished. The protocol engine gives it a one-cycle event strobe. The strobe carries three things: a flag for whether the block was good, a flag for the direction, and the 5-bit sub-address. The reporter packs these into a 7-bit reason vector and raises a level interrupt. It holds the vector steady until the host acknowledges.

Events that arrive while an interrupt is still pending wait in a small first-in-first-out queue. Each one is presented one cycle after the acknowledge that frees the line. If the queue is full, a new event is dropped and a sticky overflow flag records the loss.

A host that keeps the acknowledge input high all the time sees one single-cycle interrupt pulse per event. All inputs are sampled on the rising clock edge and all outputs are registered. Reset is asynchronous and active low, and the block releases it synchronously inside.

Top module: `xfer_irq_reporter`

## Requirements
- R1: While reset is asserted, and after it is released, `irq`, `irq_vec` and `ovf` are all 0.
- R2: The reason vector is laid out as follows:
  - bit 6 = `evt_good` (1 = good block, 0 = bad block);
  - bit 5 = `evt_tx` (1 = transmit, 0 = receive);
  - bits 4:0 = `evt_subaddr`, unchanged.

  Mode-command sub-addresses 0 and 31 pass through as given.
- R3: An event that arrives while `irq` is high and the queue already holds DEPTH entries is dropped. It also sets `ovf`, which stays 1 until reset.
- R4: With `irq` low and the queue empty, an event sampled at a clock edge makes `irq` high after that same edge, with the event's vector.
- R5: Once high, `irq` stays high and `irq_vec` stays unchanged while `ack` is low. The first edge that samples `ack` high drives `irq` low.
- R6: Queued events are presented in arrival order. `irq` is low for exactly one cycle after an acknowledge and rises again at the next edge with the next vector.
- R7: While `ack` is held high, each event produces an `irq` pulse exactly one cycle long.
- R8: An event sampled at the same edge that clears `irq` through `ack` is not lost or merged. It produces its own interrupt one cycle later.
- R9: The queue holds DEPTH (default 4) events behind the pending one without setting `ovf`, and every one of them is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle completion strobe from the protocol engine |
| evt_good | input | 1 | 1 = block good, 0 = block bad |
| evt_tx | input | 1 | 1 = transmit, 0 = receive (mode commands: transmit/receive bit of the command) |
| evt_subaddr | input | 5 | Sub-address of the transfer, or 0/31 for a mode command |
| ack | input | 1 | Interrupt acknowledge from the host |
| irq | output | 1 | Level interrupt to the host |
| irq_vec | output | 7 | Reason vector of the pending interrupt |
| ovf | output | 1 | Sticky flag: an event was dropped because the queue was full |

## Verification
The hardest situation to reach is an event landing on the very edge where a held-high acknowledge clears the interrupt of the previous event. The event must then go into the queue and come out as a separate pulse. The stimulus keeps `ack` high and issues a second event in the cycle right after the first one is raised, so the two meet on that edge. Overflow is reached the same way: the host withholds `ack` while five events arrive behind a pending one, and the bench checks that the fifth never shows up when the queue is drained.

// File: rtl/irq_rpt_pkg.sv
package irq_rpt_pkg;
  localparam int SA_W  = 5;
  localparam int VEC_W = SA_W + 2;

  typedef logic [VEC_W-1:0] irq_vec_t;

  // Reason layout: [6] block good, [5] transmit direction, [4:0] sub-address
  function automatic irq_vec_t pack_reason(input logic good, input logic tx,
                                           input logic [SA_W-1:0] sa);
    return {good, tx, sa};
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_fifo.sv
module irq_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // A push into a full queue is accepted only when a pop frees a slot.
  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= din;
  end

  assign dout  = store[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/xfer_irq_reporter.sv
module xfer_irq_reporter
  import irq_rpt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic            evt_good,
  input  logic            evt_tx,
  input  logic [SA_W-1:0] evt_subaddr,
  input  logic            ack,
  output logic            irq,
  output logic [VEC_W-1:0] irq_vec,
  output logic            ovf
);
  logic             rst_sync_n;
  irq_vec_t         evt_vec, fifo_dout, vec_q, vec_d;
  logic             irq_q, irq_d, ovf_q, ovf_d, vec_en;
  logic             q_push, q_pop, q_full, q_empty;
  logic [CNT_W-1:0] fifo_count;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign evt_vec = pack_reason(evt_good, evt_tx, evt_subaddr);

  irq_evt_fifo #(.DEPTH(DEPTH), .W(VEC_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (q_push),
    .pop   (q_pop),
    .din   (evt_vec),
    .dout  (fifo_dout),
    .count (fifo_count),
    .full  (q_full),
    .empty (q_empty)
  );

  always_comb begin
    irq_d  = irq_q;
    ovf_d  = ovf_q;
    vec_d  = vec_q;
    vec_en = 1'b0;
    q_push = 1'b0;
    q_pop  = 1'b0;
    if (irq_q) begin
      // Pending: ack clears the line; new events wait in the queue.
      if (ack) irq_d = 1'b0;
      if (evt_valid) begin
        if (q_full) ovf_d  = 1'b1;
        else        q_push = 1'b1;
      end
    end else if (!q_empty) begin
      // Line free: oldest queued event first; an arriving one goes behind.
      q_pop  = 1'b1;
      irq_d  = 1'b1;
      vec_d  = fifo_dout;
      vec_en = 1'b1;
      q_push = evt_valid;
    end else if (evt_valid) begin
      irq_d  = 1'b1;
      vec_d  = evt_vec;
      vec_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  vec_q <= '0;
    else if (vec_en)  vec_q <= vec_d;
  end

  assign irq     = irq_q;
  assign irq_vec = vec_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/xfer_irq_reporter_chk.sv
module xfer_irq_reporter_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_good,
  input logic             evt_tx,
  input logic [4:0]       evt_subaddr,
  input logic             ack,
  input logic             irq,
  input logic [6:0]       irq_vec,
  input logic             ovf,
  input logic [CNT_W-1:0] q_count
);
  // R2 / R4: idle line with empty queue takes the event directly
  p_direct_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && q_count == '0 && evt_valid) |=>
      (irq && irq_vec == {$past(evt_good), $past(evt_tx), $past(evt_subaddr)}));

  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && evt_valid) |=> irq);

  // R5: held until acknowledged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> (irq && $stable(irq_vec)));

  // R5 / R7 / R8: acknowledge always clears the line at the sampling edge
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> !irq);

  // R6: a waiting entry is presented one cycle after the line drops
  p_reraise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && q_count != '0) |=> irq);

  // R3: overflow is sticky and only caused by a full queue
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(irq && evt_valid && q_count == CNT_W'(DEPTH)));

  // R9: occupancy never exceeds capacity
  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));
endmodule

bind xfer_irq_reporter xfer_irq_reporter_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .evt_valid   (evt_valid),
  .evt_good    (evt_good),
  .evt_tx      (evt_tx),
  .evt_subaddr (evt_subaddr),
  .ack         (ack),
  .irq         (irq),
  .irq_vec     (irq_vec),
  .ovf         (ovf),
  .q_count     (fifo_count)
);

// File: tb/test_xfer_irq_reporter.sv
module test_xfer_irq_reporter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid, evt_good, evt_tx, ack;
  logic [4:0] evt_subaddr;
  logic       irq, ovf;
  logic [6:0] irq_vec;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  logic irq_prev = 1'b0;
  logic [6:0] exp_q[$];

  always #2 clk = ~clk;

  xfer_irq_reporter i_xfer_irq_reporter (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_good(evt_good),
    .evt_tx(evt_tx), .evt_subaddr(evt_subaddr), .ack(ack),
    .irq(irq), .irq_vec(irq_vec), .ovf(ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: one-cycle event; the expected vector enters the scoreboard unless dropped
  task automatic send(input logic g, input logic t, input logic [4:0] sa, input bit drop);
    evt_valid = 1'b1; evt_good = g; evt_tx = t; evt_subaddr = sa;
    if (!drop) exp_q.push_back({g, t, sa});
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // Monitor: every rising interrupt must carry the next expected vector (R6 order)
  always @(negedge clk) begin
    if (mon_on && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual=%0h expected=none (unexpected interrupt)", irq_vec);
      end else begin
        check("R6 order", irq_vec, exp_q.pop_front());
      end
    end
    irq_prev = irq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_good = 1'b0; evt_tx = 1'b0;
    evt_subaddr = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 0);
    check("R1 vec in reset", irq_vec, 0);
    check("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after release", irq, 0);
    mon_on = 1'b1;

    // R4 / R2: first event raises irq after one edge
    send(1'b1, 1'b0, 5'd5, 1'b0);
    check("R4 irq rise", irq, 1);
    check("R2 rx good vec", irq_vec, 7'h45);
    // R5: holds while ack low
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5 irq held", irq, 1);
      check("R5 vec held", irq_vec, 7'h45);
    end
    ack_pulse();
    check("R5 ack clears", irq, 0);
    @(negedge clk);

    // R2: mode-command sub-addresses 31 and 0 pass unchanged
    send(1'b0, 1'b1, 5'd31, 1'b0);
    check("R2 mode sa31 bad tx", irq_vec, 7'h3F);
    ack_pulse(); @(negedge clk);
    send(1'b1, 1'b1, 5'd0, 1'b0);
    check("R2 mode sa0 good tx", irq_vec, 7'h60);
    ack_pulse(); @(negedge clk);

    // R9 / R6: fill the queue behind a pending interrupt, then drain
    send(1'b1, 1'b0, 5'd1, 1'b0);
    for (int i = 2; i < 6; i++) send(i[0], 1'b1, 5'(i), 1'b0);
    check("R9 no overflow at capacity", ovf, 0);
    for (int i = 0; i < 4; i++) begin
      ack_pulse();
      check("R6 low after ack", irq, 0);
      @(negedge clk);
      check("R6 re-raised next cycle", irq, 1);
    end
    ack_pulse(); @(negedge clk);
    check("R9 all delivered", exp_q.size(), 0);

    // R3: fifth queued event is dropped, flag sticks
    send(1'b0, 1'b0, 5'd9, 1'b0);
    for (int i = 10; i < 14; i++) send(1'b1, 1'b0, 5'(i), 1'b0);
    check("R3 ovf before drop", ovf, 0);
    send(1'b1, 1'b1, 5'd20, 1'b1);
    check("R3 ovf set on drop", ovf, 1);
    for (int i = 0; i < 5; i++) begin
      ack_pulse(); @(negedge clk);
    end
    ack_pulse(); @(negedge clk);
    check("R3 dropped never presented", exp_q.size(), 0);
    check("R3 ovf sticky", ovf, 1);

    // R7: ack held high gives one-cycle pulses
    ack = 1'b1;
    for (int i = 0; i < 2; i++) begin
      send(1'b1, 1'b1, 5'(7 + i), 1'b0);
      check("R7 pulse high", irq, 1);
      @(negedge clk);
      check("R7 pulse one cycle", irq, 0);
      @(negedge clk);
    end

    // R8: event on the clearing edge gets its own pulse
    send(1'b0, 1'b1, 5'd3, 1'b0);
    check("R8 first pulse", irq, 1);
    send(1'b1, 1'b0, 5'd4, 1'b0);
    check("R8 first cleared", irq, 0);
    @(negedge clk);
    check("R8 second pulse", irq, 1);
    check("R8 second vector", irq_vec, 7'h44);
    @(negedge clk);
    check("R8 second pulse one cycle", irq, 0);
    ack = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 nothing lost", exp_q.size(), 0);

    // R1: reset clears the sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ovf cleared by reset", ovf, 0);
    check("R1 vec cleared by reset", irq_vec, 0);
    done = 1'b1;
    summary();
  end
endmodule